// File: doc/BRIEF.md
# Packed SIMD Saturating Adder-Subtractor

This block performs lane-parallel integer addition, subtraction and absolute value on two 64-bit operands. The operands are viewed as packed lanes whose width is chosen per operation as 8, 16 or 32 bits. Each lane is computed on its own: carries and borrows never cross into the neighbouring lane. Depending on the opcode, a lane result wraps modulo the lane width or is clamped to the signed or unsigned range of the lane.

An operation is presented with `in_valid` together with a 5-bit opcode and both operands. The result is registered and shows up with `out_valid` one clock later. Back-to-back operations are accepted every cycle. Opcodes that are not defined give an all-zero result, and `out_valid` still rises for them.

Top module: `simd_addsub`

## Requirements
- R1: `op_code[4:3]` selects the lane width (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved). `op_code[2:0]` selects the operation. Lane i occupies bits [i*W +: W], so lane 0 holds the least significant bits.
- R2: Operation 0 (add) and operation 1 (subtract, A minus B) wrap modulo 2^W in every lane for W = 8, 16 and 32. No carry or borrow passes between lanes.
- R3: Operation 3 (unsigned saturating add) for 8-bit and 16-bit lanes returns all ones in a lane whose unsigned sum exceeds the lane maximum.
- R4: Operation 2 (signed saturating add) and operation 4 (signed saturating subtract) for 8-bit and 16-bit lanes clamp each lane to -2^(W-1) .. 2^(W-1)-1.
- R5: Operation 5 (unsigned saturating subtract) for 8-bit and 16-bit lanes returns 0 in any lane where the A lane is smaller than the B lane, and A-B otherwise.
- R6: Operation 6 (absolute value of A; B is ignored) for 8-bit and 16-bit lanes negates negative lanes. The most negative lane value (0x80 or 0x8000) stays unchanged.
- R7: Lane width code 3, operation code 7, and operation codes 2 to 6 with 32-bit lanes give a result of zero.
- R8: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was sampled high, and carries the result of that operation.
- R9: A synchronous active-high `rst` clears both `out_valid` and `result`, even while `in_valid` is high.
- R10: While `in_valid` is low, `result` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture operands and opcode this cycle |
| op_code | input | 5 | {lane width[1:0], operation[2:0]} |
| op_a | input | 64 | Operand A (minuend, absolute-value source) |
| op_b | input | 64 | Operand B (addend, subtrahend) |
| out_valid | output | 1 | Result register updated by an accepted operation |
| result | output | 64 | Registered packed result |

## Verification
The assertions assume that `rst` is high at the first clock edge, and that `op_code`, `op_a` and `op_b` are known whenever `in_valid` is high. Without these, the hold and latency properties would compare undefined values. The stimulus raises reset before any edge and changes inputs only on falling edges, with the opcode and both operands always fully driven. The opcode space is swept exhaustively, including the reserved codes. Operands combine lane boundary patterns (zero, all ones, minimum and maximum signed values, mixed per-lane values) with random words. Idle gaps are inserted at random so that both the hold behaviour and back-to-back acceptance are covered.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;

  typedef enum logic [1:0] {
    SZ_B8   = 2'd0,
    SZ_H16  = 2'd1,
    SZ_W32  = 2'd2,
    SZ_RSVD = 2'd3
  } laneSize_e;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_ADDS_S = 3'd2,
    OP_ADDS_U = 3'd3,
    OP_SUBS_S = 3'd4,
    OP_SUBS_U = 3'd5,
    OP_ABS    = 3'd6,
    OP_RSVD   = 3'd7
  } laneOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;
    laneSize_e size;
    logic      isSub;
    logic      satSgn;
    logic      satUns;
    logic      isAbs;
    logic      zeroRes;
  } dpCtrl_t;

endpackage

// File: rtl/simd_addsub_lane.sv
module simd_addsub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         isSub,
  input  logic         satSgn,
  input  logic         satUns,
  input  logic         isAbs,
  output logic [W-1:0] res
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] addA;
  logic [W-1:0] addB;
  logic         cin;
  logic [W:0]   sum;
  logic [W-1:0] raw;
  logic         carry;
  logic         sOvf;

  // abs reuses the adder as 0 + ~A + 1
  always_comb begin
    if (isAbs) begin
      addA = '0;
      addB = ~opA;
      cin  = 1'b1;
    end else begin
      addA = opA;
      addB = isSub ? ~opB : opB;
      cin  = isSub;
    end
  end

  assign sum   = {1'b0, addA} + {1'b0, addB} + {{W{1'b0}}, cin};
  assign raw   = sum[W-1:0];
  assign carry = sum[W];
  assign sOvf  = (addA[W-1] == addB[W-1]) && (raw[W-1] != addA[W-1]);

  always_comb begin
    if (isAbs)
      res = opA[W-1] ? raw : opA;
    else if (satSgn && sOvf)
      res = addA[W-1] ? SMIN : SMAX;
    else if (satUns && !isSub && carry)
      res = '1;
    else if (satUns && isSub && !carry)
      res = '0;
    else
      res = raw;
  end

endmodule

// File: rtl/simd_addsub_ctrl.sv
module simd_addsub_ctrl
  import simd_addsub_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [4:0] opCode,
  output dpCtrl_t    ctrl,
  output logic       outValid
);

  laneSize_e sizeSel;
  laneOp_e   opSel;

  assign sizeSel = laneSize_e'(opCode[4:3]);
  assign opSel   = laneOp_e'(opCode[2:0]);

  always_comb begin
    ctrl         = '0;
    ctrl.capture = inValid;
    ctrl.size    = sizeSel;
    case (opSel)
      OP_SUB:    ctrl.isSub = 1'b1;
      OP_ADDS_S: ctrl.satSgn = 1'b1;
      OP_ADDS_U: ctrl.satUns = 1'b1;
      OP_SUBS_S: begin ctrl.isSub = 1'b1; ctrl.satSgn = 1'b1; end
      OP_SUBS_U: begin ctrl.isSub = 1'b1; ctrl.satUns = 1'b1; end
      OP_ABS:    ctrl.isAbs = 1'b1;
      default:   ;
    endcase
    ctrl.zeroRes = (sizeSel == SZ_RSVD) || (opSel == OP_RSVD) ||
                   ((sizeSel == SZ_W32) && (opCode[2:0] > 3'd1));
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R8

endmodule

// File: rtl/simd_addsub_dp.sv
module simd_addsub_dp
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int NUM_SIZES = 3;

  logic [NUM_SIZES-1:0][DATA_W-1:0] sizeRes;
  logic [DATA_W-1:0]                nextRes;
  logic [DATA_W-1:0]                resQ;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int W = BASE_W << k;
    localparam int N = DATA_W / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      simd_addsub_lane #(.W(W)) lane_i (
        .opA   (opA[i*W +: W]),
        .opB   (opB[i*W +: W]),
        .isSub (ctrl.isSub),
        .satSgn(ctrl.satSgn),
        .satUns(ctrl.satUns),
        .isAbs (ctrl.isAbs),
        .res   (sizeRes[k][i*W +: W])
      );
    end
  end

  always_comb begin
    nextRes = '0;
    if (!ctrl.zeroRes) begin
      case (ctrl.size)
        SZ_B8:   nextRes = sizeRes[0];
        SZ_H16:  nextRes = sizeRes[1];
        SZ_W32:  nextRes = sizeRes[2];
        default: nextRes = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               resQ <= '0;
    else if (ctrl.capture) resQ <= nextRes;
  end

  assign result = resQ;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.capture |=> $stable(resQ)); // R10
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && ctrl.zeroRes) |=> (resQ == '0)); // R7
  AST_USUB_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && !ctrl.zeroRes && ctrl.size == SZ_B8 && ctrl.satUns &&
     ctrl.isSub && (opA[7:0] < opB[7:0])) |=> (resQ[7:0] == 8'h00)); // R5
  AST_ABS_MINNEG: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && !ctrl.zeroRes && ctrl.size == SZ_H16 && ctrl.isAbs &&
     (opA[15:0] == 16'h8000)) |=> (resQ[15:0] == 16'h8000)); // R6
  AST_SSAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ctrl.capture && !ctrl.zeroRes && ctrl.size == SZ_B8 && ctrl.satSgn &&
     !ctrl.isSub && !opA[7] && !opB[7]) |=> !resQ[7]); // R4

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_addsub_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  dpCtrl_t ctrl;

  simd_addsub_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .inValid (in_valid),
    .opCode  (op_code),
    .ctrl    (ctrl),
    .outValid(out_valid)
  );

  simd_addsub_dp #(.DATA_W(DATA_W)) dp_i (
    .clk   (clk),
    .rst   (rst),
    .ctrl  (ctrl),
    .opA   (op_a),
    .opB   (op_b),
    .result(result)
  );

endmodule

// File: tb/simd_addsub_tb_top.sv
`timescale 1ns/1ps
module simd_addsub_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;

  always #2.5 clk = ~clk;

  simd_addsub dut_i (
    .clk(clk), .rst(rst), .in_valid(inValid), .op_code(opCode),
    .op_a(opA), .op_b(opB), .out_valid(outValid), .result(result)
  );

  typedef struct {
    logic [63:0] exp;
    string       tag;
    int          cyc;
  } item_t;

  item_t       sb[$];
  int          errors = 0;
  int          checks = 0;
  int          cycleCnt = 0;
  logic [63:0] lastRes = '0;
  bit          running = 0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] refModel(logic [63:0] a, logic [63:0] b, logic [4:0] op);
    int w, n;
    longint mask, ua, ub, sa, sb2, r, smin, smax;
    logic [63:0] acc;
    logic [2:0] o;
    acc = '0;
    o = op[2:0];
    if (op[4:3] == 2'd3 || o == 3'd7) return '0;
    w = 8 << op[4:3];
    if (w == 32 && o > 3'd1) return '0;
    n = 64 / w;
    mask = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -(longint'(1) << (w - 1));
    for (int i = 0; i < n; i++) begin
      ua = longint'((a >> (i * w))) & mask;
      ub = longint'((b >> (i * w))) & mask;
      sa = (ua > smax) ? ua - (mask + 1) : ua;
      sb2 = (ub > smax) ? ub - (mask + 1) : ub;
      case (o)
        3'd0: r = ua + ub;
        3'd1: r = ua - ub;
        3'd2: begin r = sa + sb2; if (r > smax) r = smax; if (r < smin) r = smin; end
        3'd3: begin r = ua + ub; if (r > mask) r = mask; end
        3'd4: begin r = sa - sb2; if (r > smax) r = smax; if (r < smin) r = smin; end
        3'd5: r = (ua < ub) ? 0 : ua - ub;
        default: r = (sa < 0) ? -sa : sa;
      endcase
      acc = acc | (64'(r & mask) << (i * w));
    end
    return acc;
  endfunction

  function automatic string tagOf(logic [4:0] op);
    if (op[4:3] == 2'd3 || op[2:0] == 3'd7 || (op[4:3] == 2'd2 && op[2:0] > 3'd1)) return "R7";
    case (op[2:0])
      3'd0, 3'd1: return "R2";
      3'd2, 3'd4: return "R4";
      3'd3:       return "R3";
      3'd5:       return "R5";
      default:    return "R6";
    endcase
  endfunction

  // driver: pushes expectation, drives one operation
  task automatic send(logic [63:0] a, logic [63:0] b, logic [4:0] op, string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b; opCode = op;
    it.exp = refModel(a, b, op);
    it.tag = (tag == "") ? tagOf(op) : tag;
    it.cyc = cycleCnt + 1;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = {$urandom, $urandom}; opB = {$urandom, $urandom}; opCode = 5'($urandom);
    end
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (!running) continue;
      if (rst) begin lastRes = '0; continue; end
      if (outValid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 spurious out_valid", result, lastRes);
        end else begin
          it = sb.pop_front();
          chk(it.cyc == cycleCnt, "R8 latency", 64'(cycleCnt), 64'(it.cyc));
          chk(result === it.exp, it.tag, result, it.exp);
        end
        lastRes = result;
      end else begin
        chk(result === lastRes, "R10 hold", result, lastRes);
      end
    end
  end

  logic [63:0] bnd [6];

  initial begin
    bnd[0] = 64'h0;
    bnd[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    bnd[2] = 64'h8000_8000_8000_8000;
    bnd[3] = 64'h7FFF_7FFF_7FFF_7FFF;
    bnd[4] = 64'h8080_7F7F_0001_FF00;
    bnd[5] = 64'h7F80_FF00_00FF_807F;

    // R9: reset state, including in_valid high during reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    inValid = 1'b1; opA = 64'h1234; opB = 64'h1; opCode = 5'd0;
    @(negedge clk);
    chk(outValid === 1'b0, "R9 out_valid in reset", 64'(outValid), 64'd0);
    chk(result === 64'h0, "R9 result in reset", result, 64'h0);
    inValid = 1'b0;
    rst = 1'b0;
    running = 1;

    // R1: lane placement, lane 0 in the least significant bits
    send(64'h0004_0003_0002_0001, 64'h0010_0020_0030_0040, 5'b01_000, "R1");
    send(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 5'b00_000, "R1");
    send(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 5'b10_000, "R2");
    idle(2);

    for (int op = 0; op < 32; op++) begin
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          send(bnd[i], bnd[j], 5'(op), "");
          if ($urandom % 5 == 0) idle(1 + $urandom % 2);
        end
      for (int r = 0; r < 16; r++) begin
        send({$urandom, $urandom}, {$urandom, $urandom}, 5'(op), "");
        if ($urandom % 4 == 0) idle(1);
      end
    end
    idle(4);

    // R9: reset mid-stream with in_valid high
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; opCode = 5'd0; opA = 64'h5; opB = 64'h5;
    @(posedge clk);
    #1;
    chk(outValid === 1'b0, "R9 out_valid after reset", 64'(outValid), 64'd0);
    chk(result === 64'h0, "R9 result after reset", result, 64'h0);
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    send(64'h8000_0001_FF80_7F00, 64'h0, 5'b00_110, "R6");
    idle(3);

    chk(sb.size() == 0, "R8 missing results", 64'(sb.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycleCnt, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule